// File: doc/BRIEF.md
# Serial EEPROM Command Slave

This block is a synchronous two-wire (I2C) slave that puts the command layer of a serial EEPROM in front of an external byte-wide RAM port. It samples SCL and SDA in the system clock, finds START, STOP and repeated START, decodes a select byte, takes a two-byte memory address, and runs byte or page writes and current, random and sequential reads. SDA is driven only through an active-low pull-down enable. The enable changes only while SCL is low.

Write data goes into a page buffer. It reaches the RAM only when a STOP arrives right after the acknowledge of a data byte. The block then stays deaf to the bus for a programmed number of clocks. A master can poll on acknowledge to learn when the write has finished. A write-protect input withholds the acknowledge from data bytes and blocks their storage. Reads are not affected by it.

Top module: `serial_mem_slave`

## Requirements
- R1: The first byte after START is received MSB first; its bits 7..4 must be 1010, bits 3..1 must equal `chipSel[2:0]`, and bit 0 selects read (1) or write (0); a matching select byte is acknowledged (SDA pulled low in the 9th clock).
- R2: A select byte that does not match is not acknowledged, and the slave acknowledges nothing more until the next START.
- R3: A write command is followed by two address bytes, high byte first, both acknowledged; address bits at and above `ADDR_W` are ignored.
- R4: With `wrProtect` low each data byte is acknowledged and buffered; bytes go to consecutive addresses whose low `PAGE_W` bits wrap inside the page, and a later byte at the same location replaces an earlier one.
- R5: With `wrProtect` high the select and address bytes are still acknowledged, but every data byte gets no acknowledge and memory stays unchanged.
- R6: A write is committed only by a STOP placed directly after a data byte's acknowledge clock; a STOP in the middle of a byte writes nothing and leaves the slave ready at once.
- R7: After a commit the slave acknowledges nothing, not even its own select byte, for `WRITE_CLKS` clocks, and then responds again.
- R8: A random read (write select, two address bytes, repeated START, read select) returns the byte at the loaded address.
- R9: A current read returns the byte at the internal counter, which advances by one after every byte sent out.
- R10: In a read, a master acknowledge continues with the next address, wrapping from the last address to 0; a master no-acknowledge ends the read.
- R11: Reads work the same with `wrProtect` high.
- R12: `sdaPullLow` only becomes asserted while the synchronised SCL is low, and is never asserted during a write cycle.
- R13: A START in the middle of any transfer aborts it and restarts select-byte reception.
- R14: After reset SDA is released and no RAM write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaPullLow | output | 1 | 1 pulls the data line low (open drain) |
| chipSel | input | 3 | Select code this slave answers to |
| wrProtect | input | 1 | 1 blocks data-byte writes |
| memAddr | output | ADDR_W | RAM address |
| memWdata | output | 8 | RAM write data |
| memWe | output | 1 | RAM write strobe |
| memRdata | input | 8 | RAM read data (combinational from memAddr) |

## Verification
The slave's SDA response follows each SCL fall after about four system clocks: two synchroniser stages, the edge detector and the output register. The bench therefore waits a full half bit period after every SCL edge before it samples acknowledges or read bits, always on the falling system-clock edge. A committed page reaches the RAM within 2^PAGE_W+1 clocks of the STOP. The bench only reads it back after waiting `WRITE_CLKS` plus a margin. To check that the slave is deaf, the bench sends a select byte well inside that window.

// File: rtl/sms_pkg.sv
package sms_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WDAT, ST_RDAT, ST_BUSY
  } smsState_e;

  // control -> datapath strobes, one clock wide
  typedef struct packed {
    logic rxShift;   // shift sampled SDA into receive byte
    logic addrHi;    // latch high address byte
    logic addrLo;    // load address counter, clear page buffer
    logic storeByte; // put receive byte into page buffer
    logic loadTx;    // fetch read byte, advance counter
    logic sweepGo;   // start copying page buffer to RAM
  } smsStrobe_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/sms_sync.sv
module sms_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);
  logic [STAGES-1:0] sclPipe, sdaPipe;
  logic sclLast, sdaLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclLast <= 1'b1;
      sdaLast <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclLast <= sclPipe[STAGES-1];
      sdaLast <= sdaPipe[STAGES-1];
    end
  end

  assign sclLvl  = sclPipe[STAGES-1];
  assign sdaLvl  = sdaPipe[STAGES-1];
  assign sclRise = sclLvl & ~sclLast;
  assign sclFall = ~sclLvl & sclLast;
  assign startEv = sclLvl & sclLast & sdaLast & ~sdaLvl;
  assign stopEv  = sclLvl & sclLast & ~sdaLast & sdaLvl;
endmodule

// File: rtl/sms_ctrl.sv
module sms_ctrl
  import sms_pkg::*;
#(
  parameter int PAGE_W     = 5,
  parameter int WRITE_CLKS = 2000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclLvl,
  input  logic       sdaLvl,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic [2:0] chipSel,
  input  logic       wrProtect,
  input  logic [7:0] rxByte,
  input  logic [7:0] txByte,
  output smsStrobe_t strobe,
  output logic       sdaPullLow,
  output logic       busy
);
  localparam int PAGE      = 1 << PAGE_W;
  localparam int BUSY_CLKS = (WRITE_CLKS > PAGE + 1) ? WRITE_CLKS : PAGE + 1;
  localparam int CNT_W     = $clog2(BUSY_CLKS + 1);

  smsState_e  state;
  logic [3:0] bitCnt;
  logic       inAck, masterAck, commitArm;
  logic [CNT_W-1:0] busyCnt;
  logic       commitOk, byteDone, ackDone, recvState;

  assign busy      = (state == ST_BUSY);
  assign byteDone  = sclFall && !inAck && (bitCnt == 4'd8);
  assign ackDone   = sclFall && inAck;
  assign recvState = (state == ST_DEV) || (state == ST_AHI) ||
                     (state == ST_ALO) || (state == ST_WDAT);
  assign commitOk  = (state == ST_WDAT) && !inAck && (bitCnt <= 4'd1) && commitArm;

  always_comb begin
    strobe = '0;
    if (!busy && !startEv && !stopEv) begin
      if (sclRise && !inAck && bitCnt < 4'd8 && recvState) strobe.rxShift = 1'b1;
      if (byteDone) begin
        strobe.addrHi    = (state == ST_AHI);
        strobe.addrLo    = (state == ST_ALO);
        strobe.storeByte = (state == ST_WDAT) && !wrProtect;
      end
      if (ackDone)
        strobe.loadTx = ((state == ST_DEV) && rxByte[0]) ||
                        ((state == ST_RDAT) && masterAck);
    end
    if (!busy && stopEv && commitOk) strobe.sweepGo = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      inAck      <= 1'b0;
      masterAck  <= 1'b0;
      commitArm  <= 1'b0;
      busyCnt    <= '0;
      sdaPullLow <= 1'b0;
    end else if (busy) begin
      sdaPullLow <= 1'b0;
      if (busyCnt == '0) state <= ST_IDLE;
      else               busyCnt <= busyCnt - 1'b1;
    end else if (startEv) begin
      state      <= ST_DEV;
      bitCnt     <= '0;
      inAck      <= 1'b0;
      commitArm  <= 1'b0;
      sdaPullLow <= 1'b0;
    end else if (stopEv) begin
      sdaPullLow <= 1'b0;
      inAck      <= 1'b0;
      bitCnt     <= '0;
      commitArm  <= 1'b0;
      if (commitOk) begin
        state   <= ST_BUSY;
        busyCnt <= CNT_W'(BUSY_CLKS - 1);
      end else begin
        state <= ST_IDLE;
      end
    end else if (state == ST_IDLE) begin
      sdaPullLow <= 1'b0;
    end else if (sclRise) begin
      if (inAck)                 masterAck <= !sdaLvl;
      else if (bitCnt < 4'd8)    bitCnt    <= bitCnt + 4'd1;
    end else if (byteDone) begin
      inAck <= 1'b1;
      case (state)
        ST_DEV:
          if (rxByte[7:1] == {DEV_TYPE, chipSel}) sdaPullLow <= 1'b1;
          else begin
            state      <= ST_IDLE;
            inAck      <= 1'b0;
            sdaPullLow <= 1'b0;
          end
        ST_AHI, ST_ALO: sdaPullLow <= 1'b1;
        ST_WDAT:        sdaPullLow <= !wrProtect;
        default:        sdaPullLow <= 1'b0;
      endcase
    end else if (ackDone) begin
      inAck      <= 1'b0;
      bitCnt     <= '0;
      sdaPullLow <= 1'b0;
      case (state)
        ST_DEV:  state <= rxByte[0] ? ST_RDAT : ST_AHI;
        ST_AHI:  state <= ST_ALO;
        ST_ALO:  state <= ST_WDAT;
        ST_WDAT: commitArm <= sdaPullLow;
        ST_RDAT: if (!masterAck) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end else if (state == ST_RDAT && !inAck && bitCnt < 4'd8 && !sclLvl) begin
      sdaPullLow <= !txByte[3'd7 - bitCnt[2:0]];
    end
  end

  // R12: pull-down only starts while SCL is low
  a_r12_oe_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !$past(sclLvl));
  // R7: silent during the write cycle
  a_r7_busy_silent: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaPullLow);
  // R6: a write cycle only starts on a STOP
  a_r6_commit_on_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopEv));
  // R13: a START always returns to select reception
  a_r13_start_restarts: assert property (@(posedge clk) disable iff (!rstN)
    (startEv && !busy) |=> (state == ST_DEV && bitCnt == 4'd0));
endmodule

// File: rtl/sms_path.sv
module sms_path
  import sms_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  smsStrobe_t        strobe,
  input  logic              sdaLvl,
  input  logic              busy,
  input  logic [7:0]        memRdata,
  output logic [7:0]        rxByte,
  output logic [7:0]        txByte,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              memWe
);
  localparam int PAGE = 1 << PAGE_W;
  localparam logic [PAGE_W-1:0] ONE_IDX  = PAGE_W'(1);
  localparam logic [PAGE_W-1:0] LAST_IDX = '1;
  localparam logic [ADDR_W-1:0] ONE_ADDR = ADDR_W'(1);

  logic [7:0]        hiByte;
  logic [ADDR_W-1:0] addrCnt;
  logic [7:0]        pageBuf [PAGE];
  logic [PAGE-1:0]   slotFull;
  logic              sweepOn;
  logic [PAGE_W-1:0] sweepIdx, offs;

  assign offs = addrCnt[PAGE_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte   <= '0;
      txByte   <= '0;
      hiByte   <= '0;
      addrCnt  <= '0;
      slotFull <= '0;
      sweepOn  <= 1'b0;
      sweepIdx <= '0;
    end else begin
      if (strobe.rxShift) rxByte <= {rxByte[6:0], sdaLvl};
      if (strobe.addrHi)  hiByte <= rxByte;
      if (strobe.addrLo) begin
        addrCnt  <= ADDR_W'({hiByte, rxByte});
        slotFull <= '0;
      end
      if (strobe.storeByte) begin
        slotFull[offs]          <= 1'b1;
        addrCnt[PAGE_W-1:0]     <= offs + ONE_IDX;
      end
      if (strobe.loadTx) begin
        txByte  <= memRdata;
        addrCnt <= addrCnt + ONE_ADDR;
      end
      if (strobe.sweepGo) begin
        sweepOn  <= 1'b1;
        sweepIdx <= '0;
      end else if (sweepOn) begin
        sweepIdx <= sweepIdx + ONE_IDX;
        if (sweepIdx == LAST_IDX) begin
          sweepOn  <= 1'b0;
          slotFull <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.storeByte) pageBuf[offs] <= rxByte;
  end

  assign memAddr  = sweepOn ? {addrCnt[ADDR_W-1:PAGE_W], sweepIdx} : addrCnt;
  assign memWdata = pageBuf[sweepIdx];
  assign memWe    = sweepOn && slotFull[sweepIdx];

  // R7: RAM is written only inside the write cycle
  a_r7_write_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);
  // R4: the page sweep keeps the page base fixed
  a_r4_sweep_in_page: assert property (@(posedge clk) disable iff (!rstN)
    (sweepOn && $past(sweepOn)) |-> $stable(memAddr[ADDR_W-1:PAGE_W]));
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
  import sms_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int PAGE_W     = 5,
  parameter int WRITE_CLKS = 2000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaPullLow,
  input  logic [2:0]        chipSel,
  input  logic              wrProtect,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              memWe,
  input  logic [7:0]        memRdata
);
  logic sclLvl, sdaLvl, sclRise, sclFall, startEv, stopEv, busy;
  logic [7:0] rxByte, txByte;
  smsStrobe_t strobe;

  sms_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rstN, .sclIn, .sdaIn, .sclLvl, .sdaLvl,
    .sclRise, .sclFall, .startEv, .stopEv
  );

  sms_ctrl #(.PAGE_W(PAGE_W), .WRITE_CLKS(WRITE_CLKS)) u_ctrl (
    .clk, .rstN, .sclLvl, .sdaLvl, .sclRise, .sclFall, .startEv, .stopEv,
    .chipSel, .wrProtect, .rxByte, .txByte, .strobe, .sdaPullLow, .busy
  );

  sms_path #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_path (
    .clk, .rstN, .strobe, .sdaLvl, .busy, .memRdata,
    .rxByte, .txByte, .memAddr, .memWdata, .memWe
  );
endmodule

// File: tb/test_serial_mem_slave.sv
module test_serial_mem_slave;
  localparam int AW = 8, PW = 5, WCLK = 300, HALF = 8, DEPTH = 1 << AW;
  localparam logic [2:0] CHIP = 3'b101;

  logic clk = 1'b0, rstN = 1'b0, sclM = 1'b1, mLow = 1'b0, wp = 1'b0;
  logic sdaPullLow, memWe, sdaLine;
  logic [AW-1:0] memAddr;
  logic [7:0] memWdata, memRdata;
  logic [7:0] ram [DEPTH];
  logic [7:0] refMem [DEPTH];
  int checks = 0, fails = 0;
  logic [AW-1:0] expPtr;
  bit ptrKnown = 0;

  always #2.5 clk = ~clk;
  assign sdaLine = !(mLow || sdaPullLow);

  serial_mem_slave #(.ADDR_W(AW), .PAGE_W(PW), .WRITE_CLKS(WCLK)) i_serial_mem_slave (
    .clk, .rstN, .sclIn(sclM), .sdaIn(sdaLine), .sdaPullLow, .chipSel(CHIP),
    .wrProtect(wp), .memAddr, .memWdata, .memWe, .memRdata
  );

  function automatic logic [7:0] initVal(int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction
  function automatic logic [AW-1:0] pageNext(logic [AW-1:0] a);
    return {a[AW-1:PW], a[PW-1:0] + 1'b1};
  endfunction

  assign memRdata = ram[memAddr];
  always @(posedge clk) begin
    if (!rstN) for (int i = 0; i < DEPTH; i++) ram[i] <= initVal(i);
    else if (memWe) ram[memAddr] <= memWdata;
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw();
    repeat (HALF) @(negedge clk);
  endtask
  task automatic busStart();
    mLow = 0; hw(); sclM = 1; hw(); mLow = 1; hw(); sclM = 0; hw();
  endtask
  task automatic busStop();
    mLow = 1; hw(); sclM = 1; hw(); mLow = 0; hw();
  endtask
  task automatic sendBits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      mLow = !b[i]; hw(); sclM = 1; hw(); sclM = 0;
    end
  endtask
  task automatic sendByte(logic [7:0] b, output bit ack);
    sendBits(b, 8);
    mLow = 0; hw(); sclM = 1; hw(); ack = !sdaLine; sclM = 0;
  endtask
  task automatic recvByte(bit giveAck, output logic [7:0] b);
    mLow = 0;
    for (int i = 7; i >= 0; i--) begin
      hw(); sclM = 1; hw(); b[i] = sdaLine; sclM = 0;
    end
    mLow = giveAck; hw(); sclM = 1; hw(); sclM = 0;
  endtask

  // write command; data bytes in dat[0..n-1]
  task automatic doWrite(logic [15:0] addr, int n, logic [7:0] dat [16], bit waitDone = 1);
    bit a;
    logic [AW-1:0] p = addr[AW-1:0];
    busStart();
    sendByte({4'b1010, CHIP, 1'b0}, a); check(a, "R1 select ack", a, 1);
    sendByte(addr[15:8], a); check(a, "R3 addr hi ack", a, 1);
    sendByte(addr[7:0], a);  check(a, "R3 addr lo ack", a, 1);
    for (int k = 0; k < n; k++) begin
      sendByte(dat[k], a);
      check(a == !wp, wp ? "R5 data noack" : "R4 data ack", a, !wp);
      if (!wp) refMem[p] = dat[k];
      p = pageNext(p);
    end
    busStop();
    ptrKnown = 0;
    if (waitDone) repeat (WCLK + 60) @(negedge clk);
  endtask

  task automatic readCheck(int n, string req);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      recvByte(k < n - 1, b);
      check(b == refMem[expPtr], req, b, refMem[expPtr]);
      expPtr = expPtr + 1'b1;
    end
    busStop();
    ptrKnown = 1;
  endtask

  task automatic randRead(logic [15:0] addr, int n, string req);
    bit a;
    busStart();
    sendByte({4'b1010, CHIP, 1'b0}, a); check(a, "R8 select ack", a, 1);
    sendByte(addr[15:8], a); sendByte(addr[7:0], a);
    busStart();
    sendByte({4'b1010, CHIP, 1'b1}, a); check(a, "R8 read select ack", a, 1);
    expPtr = addr[AW-1:0];
    readCheck(n, req);
  endtask

  task automatic curRead(int n, string req);
    bit a;
    busStart();
    sendByte({4'b1010, CHIP, 1'b1}, a); check(a, "R9 select ack", a, 1);
    readCheck(n, req);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] dat [16];
    bit a;
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) refMem[i] = initVal(i);
    repeat (5) @(negedge clk);
    check(!sdaPullLow && !memWe, "R14 reset state", {sdaPullLow, memWe}, 0);
    rstN = 1; repeat (5) @(negedge clk);

    // R3/R4: high address bits ignored, 4 bytes at 0x10
    for (int k = 0; k < 16; k++) dat[k] = 8'h30 + 8'(k);
    doWrite(16'hA510, 4, dat, 0);
    // R7: own select ignored while the write runs
    busStart(); sendByte({4'b1010, CHIP, 1'b0}, a);
    check(!a, "R7 busy noack", a, 0); busStop();
    repeat (WCLK + 60) @(negedge clk);
    busStart(); sendByte({4'b1010, CHIP, 1'b0}, a);
    check(a, "R7 ack after cycle", a, 1); busStop();
    check(ram[8'h12] == 8'h32, "R4 ram content", ram[8'h12], 8'h32);
    randRead(16'h0010, 4, "R8 R10 random sequential read");
    curRead(2, "R9 current read");

    // R4: page wrap from 0x1E
    for (int k = 0; k < 6; k++) dat[k] = 8'hC0 + 8'(k);
    doWrite(16'h001E, 6, dat);
    randRead(16'h001F, 1, "R4 page end byte");
    randRead(16'h0000, 4, "R4 wrapped bytes");

    // R5/R11: protected write, then read with protect high
    wp = 1;
    for (int k = 0; k < 3; k++) dat[k] = 8'h5A;
    doWrite(16'h0040, 3, dat);
    randRead(16'h0040, 3, "R5 R11 protected unchanged");
    wp = 0;

    // R6: STOP in the middle of a byte commits nothing
    busStart();
    sendByte({4'b1010, CHIP, 1'b0}, a); sendByte(8'h00, a); sendByte(8'h60, a);
    sendByte(8'hEE, a); sendByte(8'hEF, a); sendBits(8'hFF, 3); busStop();
    busStart(); sendByte({4'b1010, CHIP, 1'b0}, a);
    check(a, "R6 no write cycle", a, 1); busStop();
    randRead(16'h0060, 2, "R6 memory unchanged");

    // R2: wrong chip bits, then nothing acknowledged
    busStart();
    sendByte({4'b1010, 3'b010, 1'b0}, a); check(!a, "R2 mismatch noack", a, 0);
    sendByte(8'h00, a); check(!a, "R2 stays deaf", a, 0); busStop();

    // R13: START aborts an address byte
    randRead(16'h0080, 1, "R13 setup read");
    busStart();
    sendByte({4'b1010, CHIP, 1'b0}, a); sendByte(8'h00, a); sendBits(8'h33, 4);
    busStart();
    sendByte({4'b1010, CHIP, 1'b1}, a); check(a, "R13 restart select ack", a, 1);
    readCheck(1, "R13 counter kept");

    // R10: wrap at last address
    randRead(16'h00FE, 3, "R10 wrap to zero");
    curRead(1, "R9 after wrap");

    // random mix
    for (int it = 0; it < 24; it++) begin
      int op = $urandom % 3;
      if (op == 0) begin
        int n = 1 + $urandom % 8;
        wp = ($urandom % 4) == 0;
        for (int k = 0; k < n; k++) dat[k] = 8'($urandom);
        doWrite(16'($urandom), n, dat);
        wp = 0;
      end else if (op == 1 || !ptrKnown) begin
        randRead(16'($urandom), 1 + $urandom % 4, "R8 random read");
      end else begin
        curRead(1 + $urandom % 3, "R9 random current read");
      end
    end

    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule